// File: doc/BRIEF.md
# Horizontal sync and data-enable generator

This block rebuilds a clean horizontal sync pulse and a data-enable window for a pixel stream. The timing starts at the rising edge of a reference horizontal sync. An optional polarity bit first turns that reference into an active-high signal. Three programmable lengths, all counted in pixel clocks from the reference edge, set the sync width, the back porch and the active display width. The data-enable opens right after sync plus back porch and stays open for the active width. Lengths and mode bits are sampled only at a reference edge, so each line is always generated from one consistent set of values.

For outputs that carry two pixels per clock, a demultiplexed mode emits a pixel-pair clock enable that marks the first pixel of each pair. In this mode the lengths must be even. Odd values are forced even and flagged. A single-pixel shift bit moves the data-enable window one pixel earlier without touching the sync or the pair enable. Larger shifts are made by changing the sync and back-porch lengths. While the line standard is still unknown, a pass-through select sends the normalised reference sync straight to the sync output, so software gets a stable sync to classify.

Top module: `hsync_de_gen`

## Requirements
- R1: While reset is asserted, hs_out, de_out, pair_ce and odd_err are all 0.
- R2: A line starts at the clock edge where ref_hs XOR ref_inv is sampled 1 after being sampled 0 at the previous edge. With pass_sel = 0, hs_out is 1 for exactly the sync length (S) clocks that follow that edge, and 0 otherwise.
- R3: de_out is 1 for exactly the active length (A) clocks. The first of these is the clock at relative position S+B, where B is the back-porch length and position 0 is the first clock after the starting edge. It is 0 otherwise.
- R4: odd_err is registered one clock after its inputs. It is 1 when demux_en = 1 and bit 0 of any of the three lengths is 1. In demultiplexed mode, bit 0 of every latched length is cleared.
- R5: With demultiplexing off, pair_ce is 1 on every clock after reset. With it on, pair_ce is 1 at even relative positions (0, 2, 4, ...) and alternates on every clock.
- R6: In demultiplexed mode with shift_px = 1 and S+B > 0, the data-enable window starts at position S+B-1. hs_out and pair_ce are not affected. With demultiplexing off, or with S+B = 0, shift_px has no effect.
- R7: Lengths, demux_en and shift_px are latched only at a line start. A change in the middle of a line first affects the next line.
- R8: A line start that arrives before the current line is finished restarts the position at 0. The old sync and data-enable windows are abandoned.
- R9: With pass_sel = 1, hs_out equals ref_hs XOR ref_inv delayed by two clocks. pass_sel takes effect at once and does not touch de_out.
- R10: After position S+B+A-1 the line stops. hs_out and de_out stay 0 until the next line start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_hs | input | 1 | Reference horizontal sync |
| ref_inv | input | 1 | 1 treats ref_hs as active-low |
| sync_len | input | LEN_W | Sync width in clocks |
| bp_len | input | LEN_W | Back-porch length in clocks |
| act_len | input | LEN_W | Active display length in clocks |
| demux_en | input | 1 | Two-pixels-per-clock output mode |
| shift_px | input | 1 | One-pixel earlier data-enable in demultiplexed mode |
| pass_sel | input | 1 | 1 passes the reference sync to hs_out |
| hs_out | output | 1 | Active-high horizontal sync |
| de_out | output | 1 | Data-enable |
| pair_ce | output | 1 | First pixel of a pair |
| odd_err | output | 1 | Odd length given in demultiplexed mode |

## Verification
The bench builds the block with LEN_W = 6. This keeps a line of maximum length (63 + 63 + 63 clocks) short enough to run whole lines at both the all-zero and the all-ones length settings. Those runs reach the zero-width sync, the zero back porch that blocks the shift, and the counter end-of-line at its widest total. The smaller width also puts length changes in the middle of a line, early restarts and polarity flips within a short run.

// File: rtl/hsde_pkg.sv
package hsde_pkg;

    // Line mode latched at each reference edge.
    typedef struct packed {
        logic demux;      // two pixels per clock
        logic shift_eff;  // one-pixel earlier data-enable in force
    } line_mode_t;

endpackage

// File: rtl/hsde_edge.sv
module hsde_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_hs,
    input  logic ref_inv,
    output logic ref_dly,
    output logic edge_det
);
    typedef struct packed {
        logic ref_q;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     ref_norm;

    always_comb begin
        ref_norm     = ref_hs ^ ref_inv;
        st_d         = st_q;
        st_d.ref_q   = ref_norm;
        edge_det     = ref_norm & ~st_q.ref_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ref_dly = st_q.ref_q;
endmodule

// File: rtl/hsde_shadow.sv
module hsde_shadow
    import hsde_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] sync_len,
    input  logic [LEN_W-1:0] bp_len,
    input  logic [LEN_W-1:0] act_len,
    input  logic             demux_en,
    input  logic             shift_px,
    output logic [LEN_W-1:0] s_len,
    output logic [LEN_W-1:0] b_len,
    output logic [LEN_W-1:0] a_len,
    output line_mode_t       mode,
    output logic             odd_err
);
    localparam logic [LEN_W-1:0] EVEN_MASK = {{(LEN_W-1){1'b1}}, 1'b0};

    typedef struct packed {
        logic [LEN_W-1:0] s;
        logic [LEN_W-1:0] b;
        logic [LEN_W-1:0] a;
        line_mode_t       mode;
        logic             odd;
    } shd_st_t;

    shd_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.odd = demux_en & (sync_len[0] | bp_len[0] | act_len[0]);
        if (load) begin
            st_d.mode.demux = demux_en;
            if (demux_en) begin
                st_d.s = sync_len & EVEN_MASK;
                st_d.b = bp_len   & EVEN_MASK;
                st_d.a = act_len  & EVEN_MASK;
            end else begin
                st_d.s = sync_len;
                st_d.b = bp_len;
                st_d.a = act_len;
            end
            st_d.mode.shift_eff = demux_en & shift_px &
                                  ((st_d.s != '0) | (st_d.b != '0));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign s_len   = st_q.s;
    assign b_len   = st_q.b;
    assign a_len   = st_q.a;
    assign mode    = st_q.mode;
    assign odd_err = st_q.odd;
endmodule

// File: rtl/hsde_line_cnt.sv
module hsde_line_cnt #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] total,
    output logic [CNT_W-1:0] pos,
    output logic             active,
    output logic             phase
);
    typedef struct packed {
        logic [CNT_W-1:0] pos;
        logic             act;
        logic             ph;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    logic [CNT_W-1:0] pos_inc;

    always_comb begin
        st_d    = st_q;
        pos_inc = st_q.pos + CNT_W'(1);
        if (restart) begin
            st_d.pos = '0;
            st_d.act = 1'b1;
            st_d.ph  = 1'b0;
        end else begin
            st_d.ph = ~st_q.ph;
            if (st_q.act) begin
                if (pos_inc < total) st_d.pos = pos_inc;
                else                 st_d.act = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pos    = st_q.pos;
    assign active = st_q.act;
    assign phase  = st_q.ph;
endmodule

// File: rtl/hsync_de_gen.sv
module hsync_de_gen
    import hsde_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_hs,
    input  logic             ref_inv,
    input  logic [LEN_W-1:0] sync_len,
    input  logic [LEN_W-1:0] bp_len,
    input  logic [LEN_W-1:0] act_len,
    input  logic             demux_en,
    input  logic             shift_px,
    input  logic             pass_sel,
    output logic             hs_out,
    output logic             de_out,
    output logic             pair_ce,
    output logic             odd_err
);
    localparam int CNT_W = LEN_W + 2;

    typedef struct packed {
        logic hs;
        logic de;
        logic pair;
    } out_st_t;

    logic             ref_dly, edge_det;
    logic [LEN_W-1:0] s_len, b_len, a_len;
    line_mode_t       mode;
    logic [CNT_W-1:0] line_pos, line_total, de_start, de_stop;
    logic             line_act, line_ph, shift_eff;
    out_st_t          out_d, out_q;

    hsde_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_hs   (ref_hs),
        .ref_inv  (ref_inv),
        .ref_dly  (ref_dly),
        .edge_det (edge_det)
    );

    hsde_shadow #(.LEN_W(LEN_W)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (edge_det),
        .sync_len (sync_len),
        .bp_len   (bp_len),
        .act_len  (act_len),
        .demux_en (demux_en),
        .shift_px (shift_px),
        .s_len    (s_len),
        .b_len    (b_len),
        .a_len    (a_len),
        .mode     (mode),
        .odd_err  (odd_err)
    );

    hsde_line_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (edge_det),
        .total   (line_total),
        .pos     (line_pos),
        .active  (line_act),
        .phase   (line_ph)
    );

    assign shift_eff = mode.shift_eff;

    always_comb begin
        line_total = CNT_W'(s_len) + CNT_W'(b_len) + CNT_W'(a_len);
        de_start   = CNT_W'(s_len) + CNT_W'(b_len) - CNT_W'(shift_eff);
        de_stop    = de_start + CNT_W'(a_len);
        out_d.hs   = pass_sel ? ref_dly : (line_act && (line_pos < CNT_W'(s_len)));
        out_d.de   = line_act && (line_pos >= de_start) && (line_pos < de_stop);
        out_d.pair = ~mode.demux | ~line_ph;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign hs_out  = out_q.hs;
    assign de_out  = out_q.de;
    assign pair_ce = out_q.pair;
endmodule

// File: rtl/hsde_chk.sv
module hsde_chk #(
    parameter int LEN_W = 8,
    parameter int CNT_W = LEN_W + 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_hs,
    input logic             ref_inv,
    input logic [LEN_W-1:0] sync_len,
    input logic [LEN_W-1:0] bp_len,
    input logic [LEN_W-1:0] act_len,
    input logic             demux_en,
    input logic             pass_sel,
    input logic             hs_out,
    input logic             de_out,
    input logic             pair_ce,
    input logic             odd_err,
    input logic             edge_det,
    input logic             line_act,
    input logic [CNT_W-1:0] line_pos,
    input logic             shift_eff
);
    logic [1:0] up_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              up_cnt <= '0;
        else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> !(hs_out | de_out | pair_ce | odd_err));

    // R4
    odd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (demux_en && (sync_len[0] | bp_len[0] | act_len[0])) |=> odd_err);

    // R8
    edge_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_det |=> (line_act && line_pos == '0));

    // R9
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt == 2'd3 && $past(pass_sel)) |-> (hs_out == $past(ref_hs ^ ref_inv, 2)));

    // R6
    de_pair_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt != 2'd0 && $rose(de_out)) |-> (pair_ce == !$past(shift_eff)));
endmodule

bind hsync_de_gen hsde_chk #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_hs    (ref_hs),
    .ref_inv   (ref_inv),
    .sync_len  (sync_len),
    .bp_len    (bp_len),
    .act_len   (act_len),
    .demux_en  (demux_en),
    .pass_sel  (pass_sel),
    .hs_out    (hs_out),
    .de_out    (de_out),
    .pair_ce   (pair_ce),
    .odd_err   (odd_err),
    .edge_det  (edge_det),
    .line_act  (line_act),
    .line_pos  (line_pos),
    .shift_eff (shift_eff)
);

// File: tb/test_hsync_de_gen.sv
module test_hsync_de_gen;
    localparam int LW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_lvl = 1'b0;
    logic          ref_inv = 1'b0;
    logic          ref_hs;
    logic [LW-1:0] sync_len = '0, bp_len = '0, act_len = '0;
    logic          demux_en = 1'b0, shift_px = 1'b0, pass_sel = 1'b0;
    logic          hs_out, de_out, pair_ce, odd_err;

    int  n_chk = 0, n_err = 0;
    bit  cmp_en = 1'b0;

    assign ref_hs = ref_lvl ^ ref_inv;
    always #2 clk = ~clk;

    hsync_de_gen #(.LEN_W(LW)) i_hsync_de_gen (
        .clk(clk), .rst_n(rst_n), .ref_hs(ref_hs), .ref_inv(ref_inv),
        .sync_len(sync_len), .bp_len(bp_len), .act_len(act_len),
        .demux_en(demux_en), .shift_px(shift_px), .pass_sel(pass_sel),
        .hs_out(hs_out), .de_out(de_out), .pair_ce(pair_ce), .odd_err(odd_err)
    );

    // Behavioural line model
    int m_pos, m_s, m_b, m_a, m_start;
    bit m_act, m_dm, m_sh, m_ph, m_refq, m_refn;
    bit e_hs, e_de, e_pair, e_odd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = 0; m_s = 0; m_b = 0; m_a = 0; m_act = 0; m_dm = 0;
            m_sh = 0; m_ph = 0; m_refq = 0;
            e_hs = 0; e_de = 0; e_pair = 0; e_odd = 0;
        end else begin
            m_refn  = ref_hs ^ ref_inv;
            m_start = m_s + m_b - (m_sh ? 1 : 0);
            e_hs    = pass_sel ? m_refq : (m_act && m_pos < m_s);
            e_de    = m_act && m_pos >= m_start && m_pos < m_start + m_a;
            e_pair  = !m_dm || !m_ph;
            e_odd   = demux_en && (sync_len[0] || bp_len[0] || act_len[0]);
            if (m_refn && !m_refq) begin
                m_dm  = demux_en;
                m_s   = m_dm ? (int'(sync_len) / 2) * 2 : int'(sync_len);
                m_b   = m_dm ? (int'(bp_len) / 2) * 2   : int'(bp_len);
                m_a   = m_dm ? (int'(act_len) / 2) * 2  : int'(act_len);
                m_sh  = m_dm && shift_px && (m_s + m_b > 0);
                m_pos = 0; m_act = 1; m_ph = 0;
            end else begin
                m_ph = !m_ph;
                if (m_act) begin
                    if (m_pos + 1 < m_s + m_b + m_a) m_pos = m_pos + 1;
                    else                             m_act = 0;
                end
            end
            m_refq = m_refn;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s at %0t: actual %0b expected %0b", req, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            check("R2/R9 hs_out", hs_out, e_hs);
            check("R3/R6 de_out", de_out, e_de);
            check("R5 pair_ce", pair_ce, e_pair);
            check("R4 odd_err", odd_err, e_odd);
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic line(input int hi, input int lo);
        ref_lvl = 1'b1; wait_clk(hi);
        ref_lvl = 1'b0; wait_clk(lo);
    endtask

    task automatic set_len(input int s, input int b, input int a);
        sync_len = LW'(s); bp_len = LW'(b); act_len = LW'(a);
    endtask

    initial begin
        wait_clk(4);
        // R1: outputs quiet during reset
        check("R1 hs_out", hs_out, 1'b0);
        check("R1 de_out", de_out, 1'b0);
        check("R1 pair_ce", pair_ce, 1'b0);
        check("R1 odd_err", odd_err, 1'b0);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        wait_clk(3);

        // R2 R3 R10: single-pixel lines
        set_len(4, 3, 10);
        line(3, 30);
        line(5, 25);
        set_len(5, 1, 7);
        line(2, 20);
        // R6: shift has no effect in single mode
        shift_px = 1'b1;
        line(2, 20);
        shift_px = 1'b0;

        // R5: demultiplexed mode, even lengths
        demux_en = 1'b1;
        set_len(4, 2, 8);
        line(3, 24);
        // R6: one-pixel earlier data-enable
        shift_px = 1'b1;
        line(3, 24);
        // R4: odd lengths forced even and flagged
        set_len(5, 3, 9);
        line(3, 24);
        shift_px = 1'b0;
        line(3, 24);
        // R6: no shift when sync and back porch are zero
        shift_px = 1'b1;
        set_len(0, 0, 5);
        line(2, 12);
        shift_px = 1'b0;
        demux_en = 1'b0;

        // R7: mid-line change waits for the next line
        set_len(6, 2, 12);
        ref_lvl = 1'b1; wait_clk(2); ref_lvl = 1'b0; wait_clk(3);
        set_len(2, 1, 4);
        demux_en = 1'b1;
        wait_clk(20);
        demux_en = 1'b0;
        line(2, 15);

        // R8: early restart inside the active window
        set_len(3, 2, 40);
        line(2, 10);
        line(2, 8);
        line(2, 50);

        // R9: pass-through with inverted reference polarity
        ref_inv = 1'b1;
        pass_sel = 1'b1;
        line(4, 9);
        line(1, 3);
        line(6, 11);
        pass_sel = 1'b0;
        line(3, 20);
        ref_inv = 1'b0;
        wait_clk(4);

        // R10: maximum-length line then idle
        set_len(63, 63, 63);
        line(4, 200);
        set_len(0, 0, 0);
        line(2, 10);

        cmp_en = 1'b0;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #400000;
        n_err++;
        $display("FAIL watchdog: actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule